// File: doc/BRIEF.md
# Serial Flash Deep Sleep and Wake Controller

This block is the slave-side command logic of a serial memory that puts the device into a deep sleep state, wakes it up again, and can return a one-byte device identifier. It watches the serial clock, chip select (active low) and serial data-in pins. It samples those pins with its own system clock, so the serial clock must run well below the system clock rate. Opcode and dummy bits are taken on rising serial-clock edges while chip select is low.

The sleep opcode (B9h) starts a timed entry into deep sleep. The wake opcode (ABh) has two forms:

- **Short form.** Chip select rises right after the eighth opcode bit. This form starts a wake-up that lasts `T_RES_SHORT` system clocks.
- **Identifier form.** Three dummy bytes follow the opcode. The block then streams the identifier on falling serial-clock edges, MSB first, and repeats it until chip select rises. If this form is used in deep sleep, the wake-up lasts `T_RES_LONG` system clocks.

A write-in-progress input from the rest of the memory blocks both commands. The output pin is modelled as a data bit plus an output enable. Enable low means the pin is high-impedance.

Top module: `flash_sleep_ctrl`

## Requirements
- R1: After reset the power state output is 0 (standby), `ready` is 1 and `so_oe` is 0. State encoding: 0 standby, 1 entering sleep, 2 asleep, 3 waking.
- R2: In standby, opcode B9h with chip select rising after exactly 8 bits, and `wip` low, moves the state to 1. The state then becomes 2 after `T_DP` cycles, and `ready` is 0 meanwhile.
- R3: Opcode B9h sent while `wip` is high leaves the power state unchanged.
- R4: Opcode B9h with chip select rising after 7 or after 9 bits leaves the power state unchanged.
- R5: Asleep, opcode ABh with chip select rising after exactly 8 bits moves the state to 3, and then to 0 after `T_RES_SHORT` cycles.
- R6: After ABh plus 24 dummy bits (32 rising edges), each later falling serial-clock edge drives the next identifier bit, MSB first, with `so_oe` high. The byte repeats without limit, and `so_oe` returns low once chip select rises.
- R7: The identifier form of ABh issued while asleep moves the state to 3, and then to 0 after `T_RES_LONG` cycles. `T_RES_LONG` differs from `T_RES_SHORT`.
- R8: Opcode ABh sent while asleep with `wip` high leaves the state at 2.
- R9: While asleep, every opcode other than ABh is ignored: the state stays 2 and `so_oe` stays 0.
- R10: If chip select rises after ABh but partway through the dummy bytes, the block neither wakes nor drives `so_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock (idles low) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| wip | input | 1 | Write/erase/program cycle in progress |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for `spi_so`; low means high-impedance |
| pwr_state | output | 2 | Power state (0 standby, 1 entering, 2 asleep, 3 waking) |
| ready | output | 1 | High only in standby |

## Verification
The assertion on write-in-progress assumes `wip` is constant across a whole transaction and for a few cycles after chip select rises. The stimulus changes `wip` only while chip select is high and the block is idle. The assertions also assume every serial-clock phase lasts longer than the input synchronizer delay. The bench holds each phase for eight system clocks, so every pin change is seen as a clean edge before the next one.

// File: rtl/flash_sleep_pkg.sv
package flash_sleep_pkg;

    typedef enum logic [1:0] {
        PS_STANDBY  = 2'd0,
        PS_ENTERING = 2'd1,
        PS_DOWN     = 2'd2,
        PS_WAKING   = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_SLEEP,
        EV_WAKE_SHORT,
        EV_WAKE_LONG
    } cmd_event_e;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
        logic cs_active;
        logic si;
    } pin_sample_t;

    localparam logic [7:0] OP_SLEEP    = 8'hB9;
    localparam logic [7:0] OP_WAKE     = 8'hAB;
    localparam int         OPCODE_BITS = 8;
    localparam int         DUMMY_BITS  = 24;

    // Whether an opcode may act in a given power state.
    function automatic logic cmd_allowed(pwr_state_e st, logic [7:0] op, logic busy);
        return !busy && ((st == PS_STANDBY) || (st == PS_DOWN && op == OP_WAKE));
    endfunction

endpackage

// File: rtl/flash_sleep_pin_sync.sv
module flash_sleep_pin_sync
    import flash_sleep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck_i,
    input  logic        cs_n_i,
    input  logic        si_i,
    output pin_sample_t smp_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_p, cs_p, si_p;
    logic              sck_d, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sck_i};
            cs_p  <= {cs_p[STAGES-2:0], cs_n_i};
            si_p  <= {si_p[STAGES-2:0], si_i};
            sck_d <= sck_p[TOP];
            cs_d  <= cs_p[TOP];
        end
    end

    always_comb begin
        smp_o.sck_rise  = sck_p[TOP] & ~sck_d & ~cs_p[TOP];
        smp_o.sck_fall  = ~sck_p[TOP] & sck_d & ~cs_p[TOP];
        smp_o.cs_rise   = cs_p[TOP] & ~cs_d;
        smp_o.cs_active = ~cs_p[TOP];
        smp_o.si        = si_p[TOP];
    end

endmodule

// File: rtl/flash_sleep_decoder.sv
module flash_sleep_decoder
    import flash_sleep_pkg::*;
#(
    parameter int          ID_W   = 8,
    parameter logic [ID_W-1:0] DEV_ID = 8'h13
) (
    input  logic        clk,
    input  logic        rst,
    input  pin_sample_t smp,
    input  pwr_state_e  state,
    input  logic        wip,
    output cmd_event_e  ev_o,
    output logic        so_o,
    output logic        so_oe_o
);
    localparam int FRAME_BITS = OPCODE_BITS + DUMMY_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int IDX_W      = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(OPCODE_BITS);
    localparam logic [CNT_W-1:0] CNT_OP_M1 = CNT_W'(OPCODE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FR    = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_FR_M1 = CNT_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(ID_W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       op_sr;
    logic             accept_q, stream_q, so_q, oe_q;
    logic [IDX_W-1:0] id_idx;
    cmd_event_e       ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            op_sr    <= '0;
            accept_q <= 1'b0;
            stream_q <= 1'b0;
            so_q     <= 1'b0;
            oe_q     <= 1'b0;
            id_idx   <= IDX_TOP;
            ev_q     <= EV_NONE;
        end else begin
            ev_q <= EV_NONE;
            if (!smp.cs_active) begin
                if (smp.cs_rise && accept_q && !wip) begin
                    if (bit_cnt == CNT_OP && op_sr == OP_SLEEP)
                        ev_q <= EV_SLEEP;
                    else if (bit_cnt == CNT_OP && op_sr == OP_WAKE)
                        ev_q <= EV_WAKE_SHORT;
                    else if (stream_q)
                        ev_q <= EV_WAKE_LONG;
                end
                bit_cnt  <= '0;
                accept_q <= 1'b0;
                stream_q <= 1'b0;
                oe_q     <= 1'b0;
                id_idx   <= IDX_TOP;
            end else begin
                if (smp.sck_rise) begin
                    if (bit_cnt < CNT_FR)
                        bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt < CNT_OP)
                        op_sr <= {op_sr[6:0], smp.si};
                    if (bit_cnt == CNT_OP_M1)
                        accept_q <= cmd_allowed(state, {op_sr[6:0], smp.si}, wip);
                    if (bit_cnt == CNT_FR_M1 && op_sr == OP_WAKE && accept_q)
                        stream_q <= 1'b1;
                end
                if (smp.sck_fall && stream_q) begin
                    so_q   <= DEV_ID[id_idx];
                    oe_q   <= 1'b1;
                    id_idx <= (id_idx == '0) ? IDX_TOP : id_idx - 1'b1;
                end
            end
        end
    end

    assign ev_o    = ev_q;
    assign so_o    = so_q;
    assign so_oe_o = oe_q;

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_FR);
    assert_oe_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (oe_q && !smp.cs_active) |=> !oe_q);
    assert_stream_needs_frame_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(stream_q) |-> bit_cnt == CNT_FR);

endmodule

// File: rtl/flash_sleep_power_fsm.sv
module flash_sleep_power_fsm
    import flash_sleep_pkg::*;
#(
    parameter int T_DP        = 40,
    parameter int T_RES_SHORT = 60,
    parameter int T_RES_LONG  = 150
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_event_e ev,
    input  logic       wip,
    output pwr_state_e state_o
);
    localparam int MAX_A = (T_DP > T_RES_SHORT) ? T_DP : T_RES_SHORT;
    localparam int MAX_D = (MAX_A > T_RES_LONG) ? MAX_A : T_RES_LONG;
    localparam int DLY_W = $clog2(MAX_D + 1);

    pwr_state_e       state;
    logic [DLY_W-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_STANDBY;
            dly   <= '0;
        end else begin
            unique case (state)
                PS_STANDBY: if (ev == EV_SLEEP) begin
                    state <= PS_ENTERING;
                    dly   <= DLY_W'(T_DP - 1);
                end
                PS_ENTERING: if (dly == '0) state <= PS_DOWN;
                             else dly <= dly - 1'b1;
                PS_DOWN: if (ev == EV_WAKE_SHORT) begin
                    state <= PS_WAKING;
                    dly   <= DLY_W'(T_RES_SHORT - 1);
                end else if (ev == EV_WAKE_LONG) begin
                    state <= PS_WAKING;
                    dly   <= DLY_W'(T_RES_LONG - 1);
                end
                PS_WAKING: if (dly == '0) state <= PS_STANDBY;
                           else dly <= dly - 1'b1;
            endcase
        end
    end

    assign state_o = state;

    assert_down_from_entering_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DOWN && $past(state) != PS_DOWN) |-> $past(state) == PS_ENTERING);
    assert_sleep_needs_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ENTERING && $past(state) == PS_STANDBY) |-> !$past(wip));
    assert_wake_from_down_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAKING && $past(state) != PS_WAKING) |-> $past(state) == PS_DOWN);
    assert_delay_bound_R7: assert property (@(posedge clk) disable iff (rst)
        dly <= DLY_W'(MAX_D));

endmodule

// File: rtl/flash_sleep_ctrl.sv
module flash_sleep_ctrl
    import flash_sleep_pkg::*;
#(
    parameter int          T_DP        = 40,
    parameter int          T_RES_SHORT = 60,
    parameter int          T_RES_LONG  = 150,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  DEV_ID      = 8'h13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_si,
    input  logic       wip,
    output logic       spi_so,
    output logic       spi_so_oe,
    output logic [1:0] pwr_state,
    output logic       ready
);
    pin_sample_t smp;
    cmd_event_e  ev;
    pwr_state_e  state;

    flash_sleep_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
        .si_i(spi_si), .smp_o(smp)
    );

    flash_sleep_decoder #(.ID_W(8), .DEV_ID(DEV_ID)) dec_i (
        .clk(clk), .rst(rst), .smp(smp), .state(state), .wip(wip),
        .ev_o(ev), .so_o(spi_so), .so_oe_o(spi_so_oe)
    );

    flash_sleep_power_fsm #(.T_DP(T_DP), .T_RES_SHORT(T_RES_SHORT),
                            .T_RES_LONG(T_RES_LONG)) fsm_i (
        .clk(clk), .rst(rst), .ev(ev), .wip(wip), .state_o(state)
    );

    assign pwr_state = state;
    assign ready     = (state == PS_STANDBY);

    assert_oe_when_listening_R9: assert property (@(posedge clk) disable iff (rst)
        spi_so_oe |-> (state == PS_STANDBY || state == PS_DOWN));

endmodule

// File: tb/flash_sleep_ctrl_tb.sv
module flash_sleep_ctrl_tb_top;
    localparam int T_DP = 40, T_RS = 60, T_RL = 150;
    localparam logic [7:0] ID = 8'h13;
    localparam int H = 8;

    logic clk = 0, rst = 1, sck = 0, cs_n = 1, si = 0, wip = 0;
    logic so, so_oe, rdy;
    logic [1:0] st;
    int tests = 0, fails = 0;
    bit done = 0, oe_seen = 0;

    always #2 clk = ~clk;

    flash_sleep_ctrl #(.T_DP(T_DP), .T_RES_SHORT(T_RS), .T_RES_LONG(T_RL),
                       .DEV_ID(ID)) dut_i (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .wip(wip), .spi_so(so), .spi_so_oe(so_oe), .pwr_state(st), .ready(rdy)
    );

    always @(posedge clk) if (so_oe) oe_seen <= 1;

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clock_bit(logic b);
        si = b; wait_clks(H);
        sck = 1; wait_clks(H);
        sck = 0;
    endtask

    task automatic xfer(logic [7:0] op, int nbits, logic busy);
        wip = busy; wait_clks(2);
        cs_n = 0; wait_clks(H);
        for (int i = 0; i < nbits; i++) clock_bit(i < 8 ? op[7 - i] : 1'b0);
        wait_clks(H);
        cs_n = 1;
        wait_clks(6);
        wip = 0;
    endtask

    // ABh + 24 dummy bits, then nread identifier bits checked (R6)
    task automatic read_id(int nread);
        cs_n = 0; wait_clks(H);
        for (int i = 0; i < 32; i++) clock_bit(i < 8 ? 8'hAB >> (7 - i) : 1'b0);
        for (int k = 0; k < nread; k++) begin
            wait_clks(H);
            check("R6 id bit", int'(so), int'(ID[7 - (k % 8)]));
            check("R6 oe", int'(so_oe), 1);
            sck = 1; wait_clks(H); sck = 0;
        end
        wait_clks(H);
        cs_n = 1;
    endtask

    // {opcode, bit count, wip, expected state after settling}
    localparam logic [16:0] VEC [10] = '{
        {8'hB9, 6'd8,  1'b1, 2'd0},  // R3
        {8'hB9, 6'd7,  1'b0, 2'd0},  // R4
        {8'hB9, 6'd9,  1'b0, 2'd0},  // R4
        {8'hB9, 6'd8,  1'b0, 2'd2},  // R2
        {8'h9F, 6'd8,  1'b0, 2'd2},  // R9
        {8'hB9, 6'd8,  1'b0, 2'd2},  // R9 sleep opcode while asleep
        {8'hAB, 6'd8,  1'b1, 2'd2},  // R8
        {8'hAB, 6'd20, 1'b0, 2'd2},  // R10
        {8'hAB, 6'd8,  1'b0, 2'd0},  // R5
        {8'hB9, 6'd8,  1'b0, 2'd2}   // R2
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst = 0;
        wait_clks(2);
        check("R1 state", int'(st), 0);
        check("R1 ready", int'(rdy), 1);
        check("R1 oe", int'(so_oe), 0);

        for (int i = 0; i < 10; i++) begin
            oe_seen = 0;
            xfer(VEC[i][16:9], int'(VEC[i][8:3]), VEC[i][2]);
            wait_clks(200);
            check($sformatf("R2-table vec %0d state", i), int'(st), int'(VEC[i][1:0]));
            check($sformatf("R9 vec %0d no oe", i), int'(oe_seen), 0);
        end

        // R5: short wake timing (asleep now)
        xfer(8'hAB, 8, 0);
        wait_clks(14);
        check("R5 waking", int'(st), 3);
        check("R5 not ready", int'(rdy), 0);
        wait_clks(70);
        check("R5 standby", int'(st), 0);

        // R6: identifier in standby, repeats over two bytes
        read_id(16);
        wait_clks(10);
        check("R6 oe released", int'(so_oe), 0);
        check("R6 still standby", int'(st), 0);

        // R2: sleep entry timing
        xfer(8'hB9, 8, 0);
        wait_clks(14);
        check("R2 entering", int'(st), 1);
        check("R2 not ready", int'(rdy), 0);
        wait_clks(40);
        check("R2 asleep", int'(st), 2);

        // R7: identifier form while asleep uses long wake delay
        read_id(8);
        wait_clks(84);
        check("R7 still waking", int'(st), 3);
        wait_clks(90);
        check("R7 standby", int'(st), 0);
        check("R7 ready", int'(rdy), 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule